// File: doc/BRIEF.md
# Counter-Addressed Serial-Load Bit Bank

This block stores a small row of single-bit entries that are filled one bit at a time from a serial data pin. An internal write pointer selects the entry that receives the next bit. A separate increment input moves the pointer forward on its falling edge. A write strobe copies the data bit into the selected entry for as long as the strobe is high. Every entry is visible at once on a parallel output bus, which is gated by an active-low drive enable.

A full indication goes active when the strobe is released while the pointer sits at the last entry. It stays active until the next clear. The indication is presented as a sink request. Several banks can then share one open-drain line, and any bank that is full pulls that line low.

A level-sensitive clear input empties every entry, returns the pointer to zero and releases the full indication. All control pins are sampled once per system clock, and edges are found by comparing each sample with the one before it. The pins are plain level signals with no valid/ready handshake. Data leaves only when the strobe commands a write, so there is no back-pressure.

Top module: `serial_latch_bank`

## Requirements
- R1: After the system reset, and in the cycle after a sampled high on `clr`, every entry reads 0, the pointer is at entry 0 and `full_sink` is 0.
- R2: Each sampled falling edge of `inc` moves the pointer up by one. From the last entry (index DEPTH-1) it moves to entry 0.
- R3: While the sampled `stb` is high, the sampled `din` is written into the entry the pointer selects, and every other entry keeps its value.
- R4: When `drive_n` is 0, `bus_oe` is 1 and bit i of `bus_q` carries entry i. When `drive_n` is 1, `bus_oe` is 0 and `bus_q` is all zeros. Both respond combinationally.
- R5: A sampled falling edge of `stb` sets `full_sink` to 1 only when the pointer is at entry DEPTH-1. At any other entry, the full state is unchanged.
- R6: Once `full_sink` is 1, it stays 1 until a clear, whatever happens on `inc` or `stb`.
- R7: While the sampled `clr` is high, edges on `inc` and `stb` have no effect: the pointer stays at 0, the entries stay 0 and `full_sink` stays 0.
- R8: Each edge acts only once. Holding `inc` low or high for many cycles gives at most one pointer step, and a pointer step uses the pointer value from before the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr | input | 1 | Master clear, level, active high |
| inc | input | 1 | Pointer advance, acts on its falling edge |
| stb | input | 1 | Write strobe, level, active high |
| din | input | 1 | Serial data bit |
| drive_n | input | 1 | Active-low parallel output enable |
| bus_q | output | DEPTH | Parallel view of all entries, zero when not driven |
| bus_oe | output | 1 | Output-enable for an external three-state driver |
| full_sink | output | 1 | 1 requests a pull-down on a shared open-drain full line |

## Verification
The embedded assertions check the following on every cycle:
- the pointer stays put unless a falling edge on `inc` arrives, and steps by exactly one when it does;
- at most one entry changes per cycle, and no entry changes without the strobe;
- a clear empties the whole state;
- the full state is sticky and is set by a strobe release at the last entry;
- the bus reads zero whenever it is not driven.

Only the bench's scenarios can show where the pointer actually points, by writing a bit and seeing which bus position changes. The same holds for the wrap after the last entry, for edges swallowed while clear is held, and for the two-entry write that happens when the strobe stays high across a pointer step. These are checked against a bench model under directed sequences and seeded random pin activity.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int unsigned SLB_DEPTH_DEFAULT = 8;

  // Edge-tracked control pins, in sampler bit order
  typedef enum int unsigned {
    EDGE_INC = 0,
    EDGE_STB = 1,
    EDGE_NUM = 2
  } edge_idx_e;

  // Level-only pins, in sampler bit order
  typedef enum int unsigned {
    LVL_CLR = 0,
    LVL_DIN = 1,
    LVL_NUM = 2
  } lvl_idx_e;
endpackage

// File: rtl/slb_sampler.sv
module slb_sampler #(
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned EDGE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  lvl_in,
  input  logic [EDGE_W-1:0] edge_in,
  output logic [LVL_W-1:0]  lvl_out,
  output logic [EDGE_W-1:0] edge_lvl,
  output logic [EDGE_W-1:0] edge_fall
);
  logic [LVL_W-1:0] lvl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_in;
  end
  assign lvl_out = lvl_q;

  for (genvar g = 0; g < EDGE_W; g++) begin : g_edge
    logic cur_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        cur_q  <= edge_in[g];
        prev_q <= cur_q;
      end
    end
    assign edge_lvl[g]  = cur_q;
    assign edge_fall[g] = prev_q & ~cur_q;

    // R8: a fall lasts exactly one cycle
    p_fall_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_fall[g] |=> !edge_fall[g]);
  end
endmodule

// File: rtl/slb_pointer.sv
module slb_pointer #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_lvl,
  input  logic             inc_fall,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (clr)      ptr_q <= '0;
    else if (inc_fall) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
  end
  assign ptr = ptr_q;

  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc_fall) |=> $stable(ptr_q));
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc_fall && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + PTR_W'(1));
  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc_fall && ptr_q == LAST) |=> ptr_q == '0);
  p_ptr_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr_q == '0);
  p_ptr_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc_lvl) |=> $stable(ptr_q));
endmodule

// File: rtl/slb_bank.sv
module slb_bank #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb_lvl,
  input  logic             din,
  input  logic [PTR_W-1:0] ptr,
  output logic [DEPTH-1:0] bits
);
  logic [DEPTH-1:0] sel;
  logic [DEPTH-1:0] bits_q;

  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ptr == PTR_W'(i)) sel[i] = 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bits_q[g] <= 1'b0;
      else if (clr)                bits_q[g] <= 1'b0;
      else if (stb_lvl && sel[g])  bits_q[g] <= din;
    end
  end
  assign bits = bits_q;

  p_bank_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> bits_q == '0);
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !stb_lvl) |=> $stable(bits_q));
  p_bank_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $countones(bits_q ^ $past(bits_q)) <= 1);
  p_bank_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stb_lvl) |=> bits_q[$past(ptr)] == $past(din));
endmodule

// File: rtl/slb_full.sv
module slb_full #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb_fall,
  input  logic [PTR_W-1:0] ptr,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic full_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         full_q <= 1'b0;
    else if (clr)                       full_q <= 1'b0;
    else if (stb_fall && ptr == LAST)   full_q <= 1'b1;
  end
  assign full = full_q;

  p_full_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && stb_fall && ptr == LAST) |=> full_q);
  p_full_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && !(stb_fall && ptr == LAST)) |=> !full_q);
  p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr) |=> full_q);
  p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !full_q);
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank #(
  parameter int unsigned DEPTH = slb_pkg::SLB_DEPTH_DEFAULT,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic             stb,
  input  logic             din,
  input  logic             drive_n,
  output logic [DEPTH-1:0] bus_q,
  output logic             bus_oe,
  output logic             full_sink
);
  import slb_pkg::*;

  logic [LVL_NUM-1:0]  lvl_raw, lvl_s;
  logic [EDGE_NUM-1:0] edge_raw, edge_s, edge_f;
  logic [PTR_W-1:0]    ptr;
  logic [DEPTH-1:0]    bits;
  logic                full;

  always_comb begin
    lvl_raw           = '0;
    lvl_raw[LVL_CLR]  = clr;
    lvl_raw[LVL_DIN]  = din;
    edge_raw          = '0;
    edge_raw[EDGE_INC] = inc;
    edge_raw[EDGE_STB] = stb;
  end

  slb_sampler #(.LVL_W(LVL_NUM), .EDGE_W(EDGE_NUM)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .lvl_in(lvl_raw), .edge_in(edge_raw),
    .lvl_out(lvl_s), .edge_lvl(edge_s), .edge_fall(edge_f)
  );

  slb_pointer #(.DEPTH(DEPTH)) u_pointer (
    .clk(clk), .rst_n(rst_n), .clr(lvl_s[LVL_CLR]),
    .inc_lvl(edge_s[EDGE_INC]), .inc_fall(edge_f[EDGE_INC]), .ptr(ptr)
  );

  slb_bank #(.DEPTH(DEPTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(lvl_s[LVL_CLR]),
    .stb_lvl(edge_s[EDGE_STB]), .din(lvl_s[LVL_DIN]), .ptr(ptr), .bits(bits)
  );

  slb_full #(.DEPTH(DEPTH)) u_full (
    .clk(clk), .rst_n(rst_n), .clr(lvl_s[LVL_CLR]),
    .stb_fall(edge_f[EDGE_STB]), .ptr(ptr), .full(full)
  );

  assign bus_oe    = ~drive_n;
  assign bus_q     = bus_oe ? bits : '0;
  assign full_sink = full;

  p_bus_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_n |-> (bus_q == '0 && !bus_oe));
  p_clr_swallow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_s[LVL_CLR] |=> (bits == '0 && ptr == '0 && !full_sink));
endmodule

// File: tb/serial_latch_bank_tb.sv
`timescale 1ns/1ps
module serial_latch_bank_tb;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 0, inc = 0, stb = 0, din = 0, drive_n = 0;
  logic [DEPTH-1:0] bus_q;
  logic bus_oe, full_sink;

  always #5 clk = ~clk;

  serial_latch_bank #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .stb(stb), .din(din),
    .drive_n(drive_n), .bus_q(bus_q), .bus_oe(bus_oe), .full_sink(full_sink)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of the requirements
  logic [DEPTH-1:0] m_mem = '0;
  int m_ptr = 0;
  bit m_full = 0;
  bit p_inc = 0, p_stb = 0;

  function automatic logic [DEPTH-1:0] exp_bus(logic [DEPTH-1:0] mem, bit drv_n);
    return drv_n ? '0 : mem;
  endfunction

  function automatic int next_ptr(int p);
    return (p == DEPTH - 1) ? 0 : p + 1;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " bus"}, 64'(bus_q), 64'(exp_bus(m_mem, drive_n)));
    chk({tag, " oe"},  64'(bus_oe), 64'(!drive_n));
    chk({tag, " full"}, 64'(full_sink), 64'(m_full));
  endtask

  // drive a pin pattern, hold it three clocks, update the model
  task automatic step(bit n_clr, bit n_inc, bit n_stb, bit n_d, bit n_drv);
    @(negedge clk);
    clr = n_clr; inc = n_inc; stb = n_stb; din = n_d; drive_n = n_drv;
    repeat (3) @(posedge clk);
    if (n_clr) begin
      m_mem = '0; m_ptr = 0; m_full = 0;
    end else begin
      if (n_stb) m_mem[m_ptr] = n_d;
      if (p_stb && !n_stb && m_ptr == DEPTH - 1) m_full = 1;
      if (p_inc && !n_inc) m_ptr = next_ptr(m_ptr);
      if (n_stb) m_mem[m_ptr] = n_d;
    end
    p_inc = n_inc; p_stb = n_stb;
    @(negedge clk);
  endtask

  task automatic write_bit(bit d);
    step(0, 0, 1, d, 0);
    step(0, 0, 0, d, 0);
  endtask

  task automatic bump();
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [DEPTH-1:0] pat;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 in-reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_all("R1 reset state");

    // fill all entries in pointer order
    pat = 8'b1011_0110;
    for (int i = 0; i < DEPTH; i++) begin
      write_bit(pat[i]);
      check_all("R3 serial fill");
      if (i < DEPTH - 1) chk("R5 not full before last", 64'(full_sink), 64'd0);
      bump();
    end
    chk("R5 full after last strobe", 64'(full_sink), 64'd1);
    chk("R3 pattern", 64'(bus_q), 64'(pat));

    // pointer wrapped to entry 0
    write_bit(1'b0);
    chk("R2 wrap writes bit0", 64'(bus_q), 64'(pat & 8'hFE));
    check_all("R6 full held");
    bump(); bump();
    chk("R6 full after incs", 64'(full_sink), 64'd1);

    // drive disabled
    step(0, 0, 0, 0, 1);
    chk("R4 oe low", 64'(bus_oe), 64'd0);
    chk("R4 bus zero", 64'(bus_q), 64'd0);
    step(0, 0, 0, 0, 0);
    check_all("R4 re-enabled");

    // clear, with edges during it
    step(1, 0, 0, 0, 0);
    check_all("R1 clear");
    step(1, 1, 1, 1, 0);
    step(1, 0, 0, 1, 0);
    step(1, 1, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    chk("R7 edges ignored bus", 64'(bus_q), 64'd0);
    chk("R7 edges ignored full", 64'(full_sink), 64'd0);
    step(0, 0, 0, 0, 0);
    write_bit(1'b1);
    chk("R7 pointer stayed 0", 64'(bus_q), 64'd1);

    // long-held inc levels advance once
    step(0, 1, 0, 0, 0);
    repeat (20) @(posedge clk);
    step(0, 0, 0, 0, 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    write_bit(1'b1);
    chk("R8 single step", 64'(bus_q), 64'h3);

    // strobe held over a pointer step writes both entries
    step(0, 1, 1, 1, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    check_all("R8 step uses old pointer");
    chk("R8 two entries", 64'(bus_q), 64'h7 | 64'(m_mem));

    // strobe release at non-last entry
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH - 2; i++) bump();
    write_bit(1'b1);
    chk("R5 release at entry 6", 64'(full_sink), 64'd0);
    bump();
    write_bit(1'b1);
    chk("R5 release at last", 64'(full_sink), 64'd1);
    chk("R3 last two bits", 64'(bus_q), 64'hC0);

    // seeded random pin activity
    for (int n = 0; n < 400; n++) begin
      bit rc;
      rc = ($urandom % 20) == 0;
      step(rc, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 6) == 0);
      check_all("R2/R3/R5 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule